// File: doc/BRIEF.md
# Endpoint Enable and Reset Controller

This block holds the enable and reset control for the eight endpoints of a USB device controller. Software reaches it through one 32-bit register on a simple single-cycle read/write bus. Each endpoint has one enable bit and one reset bit in that register. From these bits the block drives three per-endpoint signals into the endpoint logic. The first says whether the endpoint answers host requests. The second clears the endpoint's working state: FIFO byte counter, transfer status and control flags. The third clears the data-toggle bit.

The state clear is held for as long as the endpoint's reset bit is one, or for as long as the endpoint is disabled. The clear never reaches the endpoint's configuration fields (allocation, bank count, size, direction, type). It never touches the data-toggle bit either. That bit is cleared only by a separate per-endpoint strobe, which the block passes through.

A USB bus reset seen on the link clears every reset bit in hardware. Endpoints that were held in reset therefore return to normal FIFO operation. Their enable bits stay as they were.

Top module: `epGateTop`

## Requirements
- R1: After the asynchronous active-low reset, the register reads 0x00000000. All eight endpoints are then inactive and their state clears are asserted.
- R2: A write at offset 0x1C loads bits 7:0 as the enable bits of endpoints 7..0 and bits 23:16 as their reset bits. The write takes effect on the next clock edge. A read at 0x1C (select high, write low) returns that value in the same cycle.
- R3: Bits 31:24 and 15:8 of the register always read as zero and ignore writes. Writes to any offset other than 0x1C change nothing. Reads at any other offset, and any cycle without a read at 0x1C, return zero.
- R4: The active output of endpoint n equals its enable bit (bit n).
- R5: The state-clear output of endpoint n is high while its reset bit (bit 16+n) is one or its enable bit is zero. It drops in the cycle after software writes the reset bit to zero with the enable bit at one.
- R6: The data-toggle clear of endpoint n follows only that endpoint's toggle-clear request input. Reset bits and enable bits never cause it.
- R7: A cycle with the USB bus-reset input high clears all eight reset bits at the next edge and leaves the enable bits unchanged.
- R8: If a register write and a USB bus reset arrive in the same cycle, all reset bits become zero and the enable bits take the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access strobe |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 8 | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid in the same cycle |
| linkBusReset | input | 1 | USB bus reset detected on the link |
| toggleClrReq | input | 8 | Per-endpoint request to clear the data-toggle bit |
| epActive | output | 8 | Endpoint answers host requests |
| epStateClr | output | 8 | Hold endpoint FIFO, counter, status and control in reset |
| epToggleClr | output | 8 | Clear the endpoint data-toggle bit |

## Verification
Several properties are checked on every cycle. A disabled endpoint always has its state clear asserted. A toggle clear never appears without its request. Reserved read bits are zero. A bus reset leaves every reset bit at zero with the enables stable. A write to a foreign offset changes no output. The bench's reference model covers the rest of the behaviour. It checks exact register contents after each write pattern, the same-cycle collision of a write with a bus reset, and the release timing of the state clear. Those are only visible through scenarios that drive those sequences.

// File: rtl/epGatePkg.sv
package epGatePkg;
  // Decoded bus strobes handed from control to datapath
  typedef struct packed {
    logic wrHit;    // write at the register offset
    logic rdHit;    // read at the register offset
    logic linkRst;  // USB bus reset this cycle
  } regStrobe_t;
endpackage

// File: rtl/epGateCtrl.sv
module epGateCtrl
  import epGatePkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h1C
) (
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              linkBusReset,
  output regStrobe_t        strobe
);
  logic addrHit;

  always_comb begin
    addrHit        = (busAddr == REG_OFFSET);
    strobe.wrHit   = busSel && busWrite && addrHit;
    strobe.rdHit   = busSel && !busWrite && addrHit;
    strobe.linkRst = linkBusReset;
  end
endmodule

// File: rtl/epGateRegs.sv
module epGateRegs
  import epGatePkg::*;
#(
  parameter int NUM_EP  = 8,
  parameter int DATA_W  = 32,
  parameter int EN_LSB  = 0,
  parameter int RST_LSB = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [NUM_EP-1:0] toggleClrReq,
  output logic [DATA_W-1:0] busRdata,
  output logic [NUM_EP-1:0] epActive,
  output logic [NUM_EP-1:0] epStateClr,
  output logic [NUM_EP-1:0] epToggleClr
);
  logic [NUM_EP-1:0] enBits;
  logic [NUM_EP-1:0] rstBits;

  // Enable field: follows writes only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             enBits <= '0;
    else if (strobe.wrHit) enBits <= busWdata[EN_LSB +: NUM_EP];
  end

  // Reset field: link reset takes priority over a same-cycle write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rstBits <= '0;
    else if (strobe.linkRst) rstBits <= '0;
    else if (strobe.wrHit)   rstBits <= busWdata[RST_LSB +: NUM_EP];
  end

  always_comb begin
    busRdata = '0;
    if (strobe.rdHit) begin
      busRdata[EN_LSB +: NUM_EP]  = enBits;
      busRdata[RST_LSB +: NUM_EP] = rstBits;
    end
  end

  for (genvar ep = 0; ep < NUM_EP; ep++) begin : g_ep
    assign epActive[ep]    = enBits[ep];
    assign epStateClr[ep]  = rstBits[ep] | ~enBits[ep];
    assign epToggleClr[ep] = toggleClrReq[ep];
  end
endmodule

// File: rtl/epGateTop.sv
module epGateTop
  import epGatePkg::*;
#(
  parameter int NUM_EP  = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h1C,
  parameter int EN_LSB  = 0,
  parameter int RST_LSB = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              linkBusReset,
  input  logic [NUM_EP-1:0] toggleClrReq,
  output logic [NUM_EP-1:0] epActive,
  output logic [NUM_EP-1:0] epStateClr,
  output logic [NUM_EP-1:0] epToggleClr
);
  regStrobe_t strobe;

  epGateCtrl #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_ctrl (
    .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .linkBusReset(linkBusReset), .strobe(strobe)
  );

  epGateRegs #(.NUM_EP(NUM_EP), .DATA_W(DATA_W), .EN_LSB(EN_LSB), .RST_LSB(RST_LSB)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busWdata(busWdata),
    .toggleClrReq(toggleClrReq), .busRdata(busRdata), .epActive(epActive),
    .epStateClr(epStateClr), .epToggleClr(epToggleClr)
  );
endmodule

// File: rtl/epGateChk.sv
module epGateChk #(
  parameter int NUM_EP  = 8,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h1C,
  parameter int EN_LSB  = 0,
  parameter int RST_LSB = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busRdata,
  input logic              linkBusReset,
  input logic [NUM_EP-1:0] toggleClrReq,
  input logic [NUM_EP-1:0] epActive,
  input logic [NUM_EP-1:0] epStateClr,
  input logic [NUM_EP-1:0] epToggleClr
);
  localparam logic [DATA_W-1:0] FIELD = DATA_W'({NUM_EP{1'b1}});
  localparam logic [DATA_W-1:0] VALID = (FIELD << EN_LSB) | (FIELD << RST_LSB);

  // R3
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busRdata & ~VALID) == '0);

  // R5
  disabled_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (~epActive & ~epStateClr) == '0);

  // R6
  toggle_only_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (epToggleClr & ~toggleClrReq) == '0);

  // R7
  busrst_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    linkBusReset |=> (epStateClr == ~epActive));

  // R7
  busrst_keeps_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    (linkBusReset && !(busSel && busWrite)) |=> $stable(epActive));

  // R3
  foreign_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWrite && busAddr != REG_OFFSET && !linkBusReset)
      |=> ($stable(epActive) && $stable(epStateClr)));
endmodule

bind epGateTop epGateChk #(
  .NUM_EP(NUM_EP), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .REG_OFFSET(REG_OFFSET), .EN_LSB(EN_LSB), .RST_LSB(RST_LSB)
) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
  .busAddr(busAddr), .busRdata(busRdata), .linkBusReset(linkBusReset),
  .toggleClrReq(toggleClrReq), .epActive(epActive),
  .epStateClr(epStateClr), .epToggleClr(epToggleClr)
);

// File: tb/epGateTop_tb.sv
`timescale 1ns/1ps
module epGateTop_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0;
  logic        busWrite = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWdata = 32'h0;
  logic [31:0] busRdata;
  logic        linkBusReset = 1'b0;
  logic [7:0]  toggleClrReq = 8'h00;
  logic [7:0]  epActive, epStateClr, epToggleClr;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Reference state, updated behaviourally
  logic [7:0] mEn = 8'h00;
  logic [7:0] mRst = 8'h00;

  always #2 clk = ~clk;  // 250 MHz

  epGateTop u_dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .linkBusReset(linkBusReset), .toggleClrReq(toggleClrReq),
    .epActive(epActive), .epStateClr(epStateClr), .epToggleClr(epToggleClr)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mEn = 8'h00; mRst = 8'h00;
    end else begin
      if (busSel && busWrite && busAddr == 8'h1C) mEn = busWdata[7:0];
      if (linkBusReset) mRst = 8'h00;
      else if (busSel && busWrite && busAddr == 8'h1C) mRst = busWdata[23:16];
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    logic [31:0] expRd;
    expRd = (busSel && !busWrite && busAddr == 8'h1C) ? {8'h00, mRst, 8'h00, mEn} : 32'h0;
    check("R2/R3 busRdata", busRdata, expRd);
    check("R4 epActive", {24'h0, epActive}, {24'h0, mEn});
    check("R5 epStateClr", {24'h0, epStateClr}, {24'h0, mRst | ~mEn});
    check("R6 epToggleClr", {24'h0, epToggleClr}, {24'h0, toggleClrReq});
  end

  task automatic drive(input logic sel, input logic wr, input logic [7:0] a,
                       input logic [31:0] d, input logic lr, input logic [7:0] tq);
    @(negedge clk); #1;
    busSel = sel; busWrite = wr; busAddr = a; busWdata = d;
    linkBusReset = lr; toggleClrReq = tq;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 8'h00, 32'h0, 1'b0, 8'h00);
  endtask

  // Issue a read and check the value in the same cycle
  task automatic readExpect(input string tag, input logic [31:0] exp);
    drive(1'b1, 1'b0, 8'h1C, 32'h0, 1'b0, 8'h00);
    #0.5;
    check(tag, busRdata, exp);
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    // R1: reset state
    #0.5;
    check("R1 reset epActive", {24'h0, epActive}, 32'h0);
    check("R1 reset epStateClr", {24'h0, epStateClr}, 32'h0000_00FF);
    @(negedge clk); #1; rstN = 1'b1;
    readExpect("R1 reset readback", 32'h0);

    // R2: enable all, hold endpoints 1 and 6 in reset
    drive(1'b1, 1'b1, 8'h1C, 32'h0042_00FF, 1'b0, 8'h00);
    readExpect("R2 write readback", 32'h0042_00FF);
    check("R5 held in reset", {24'h0, epStateClr}, 32'h0000_0042);

    // R5: release reset, clear drops next cycle
    drive(1'b1, 1'b1, 8'h1C, 32'h0000_00FF, 1'b0, 8'h00);
    idle(); #0.5;
    check("R5 release", {24'h0, epStateClr}, 32'h0);
    check("R4 all active", {24'h0, epActive}, 32'h0000_00FF);

    // R3: reserved bits ignored
    drive(1'b1, 1'b1, 8'h1C, 32'hFF3C_FF5A, 1'b0, 8'h00);
    readExpect("R3 reserved bits", 32'h003C_005A);

    // R3: foreign offset writes ignored, foreign reads zero
    drive(1'b1, 1'b1, 8'h18, 32'h00FF_00FF, 1'b0, 8'h00);
    drive(1'b1, 1'b1, 8'h1D, 32'h0000_0000, 1'b0, 8'h00);
    readExpect("R3 foreign write ignored", 32'h003C_005A);
    drive(1'b1, 1'b0, 8'h20, 32'h0, 1'b0, 8'h00); #0.5;
    check("R3 foreign read zero", busRdata, 32'h0);

    // R6: toggle clear only from request, even while in reset / disabled
    drive(1'b0, 1'b0, 8'h00, 32'h0, 1'b0, 8'hA5); #0.5;
    check("R6 toggle passthrough", {24'h0, epToggleClr}, 32'h0000_00A5);
    idle(); #0.5;
    check("R6 no toggle from reset bits", {24'h0, epToggleClr}, 32'h0);

    // R7: bus reset clears reset bits, keeps enables
    drive(1'b0, 1'b0, 8'h00, 32'h0, 1'b1, 8'h00);
    readExpect("R7 bus reset", 32'h0000_005A);

    // R8: write and bus reset in the same cycle
    drive(1'b1, 1'b1, 8'h1C, 32'h00F0_0033, 1'b1, 8'h00);
    readExpect("R8 collision", 32'h0000_0033);
    check("R8 state clear", {24'h0, epStateClr}, 32'h0000_00CC);

    // Random traffic checked against the model each cycle
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] r;
      r = $urandom;
      drive(r[0], r[1], (r[4:2] == 3'd0) ? 8'h14 : 8'h1C, $urandom,
            (r[9:6] == 4'd0), r[17:10]);
    end
    idle(); idle();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule